// File: doc/BRIEF.md
# In-Order Request Tag Tracker

This block watches a request stream and records a context word for every non-posted request whose first beat is accepted. Up to two requests may start in one beat; they are queued oldest first, slot 0 ahead of slot 1. A downstream engine later hands back one tag per non-posted request, in request order, on two one-cycle tag ports. Port 0 always carries the older request when both fire together. The delay between a request and its tag varies, and new requests keep arriving in the meantime.

Each returned tag takes the oldest queued context and files it in a table indexed by tag. Completion logic then presents a tag on a lookup port and gets back the stored context with a hit bit. A release strobe marks a table entry free once its completion has finished. A sticky error flag records a tag that arrives with nothing pending and a non-posted request that arrives when the queue has no room.

Top module: `reqTagTracker`

## Requirements
- R1: After reset `errSticky` is 0, `lookupHit` is 0 for every tag, and no context is pending.
- R2: A context is queued for each slot s with `beatAccept`=1, `startVld[s]`=1 and `startNp[s]`=1 (1 = non-posted). A posted start (`startNp[s]`=0), or any start while `beatAccept`=0, queues nothing.
- R3: When both slots queue in one beat, the slot 0 context (`startCtx0`) is queued ahead of the slot 1 context (`startCtx1`).
- R4: Each tag taken from a tag port removes the oldest pending context and stores it in the table at that tag with its valid bit set.
- R5: When `tagVld0` and `tagVld1` are both 1, port 0 takes the oldest pending context and port 1 the next one. With only `tagVld1` set, port 1 takes the oldest.
- R6: A tag arriving while no context is pending sets `errSticky` and writes nothing into the table. This includes port 1 when only one context is pending and both ports fire.
- R7: A non-posted start that finds the queue full is dropped and sets `errSticky`. Room freed by tags taken in the same cycle counts as free space. Slot 0 gets room before slot 1. The queue holds `FIFO_DEPTH` contexts.
- R8: `releaseEn` clears the valid bit of the table entry at `releaseTag`. A tag write to the same entry in the same cycle wins, and the entry stays valid.
- R9: `lookupHit` and `lookupCtx` are registered. They show the table entry at `lookupTag` as it stood before the clock edge that samples `lookupTag`, so they appear one cycle later.
- R10: Once set, `errSticky` stays 1 until reset.
- R11: If both tag ports carry the same tag in one cycle, the entry ends up holding the context taken by port 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| beatAccept | input | 1 | Request beat transferred this cycle |
| startVld | input | 2 | Request start in slot 0 / slot 1 of the beat |
| startNp | input | 2 | Per slot: 1 = non-posted start |
| startCtx0 | input | CTX_W | Context of the slot 0 request |
| startCtx1 | input | CTX_W | Context of the slot 1 request |
| tagVld0 | input | 1 | Tag port 0 valid (one cycle) |
| tag0 | input | TAG_W | Tag port 0 value |
| tagVld1 | input | 1 | Tag port 1 valid (one cycle) |
| tag1 | input | TAG_W | Tag port 1 value |
| lookupTag | input | TAG_W | Tag to look up |
| lookupHit | output | 1 | Looked-up entry is valid (registered) |
| lookupCtx | output | CTX_W | Looked-up context (registered) |
| releaseEn | input | 1 | Release strobe |
| releaseTag | input | TAG_W | Tag whose entry is released |
| errSticky | output | 1 | Sticky underflow/overflow error |

## Verification
A request or tag presented before clock edge N changes the queue and the table at edge N. `errSticky` reflects an error at edge N. A lookup of that tag shows the new entry at edge N+1, because the lookup register reads the table as it stood before edge N.

The bench drives inputs on falling edges and compares outputs on the next falling edge against a queue-and-map model. That model advances on the rising edge with the same ordering: lookup first, then tags, release, pushes. Directed checks sample exactly one and two falling edges after a tag to confirm the one-cycle lookup lag. Other directed checks fill the queue to its depth, where a same-cycle tag frees a slot and the next start is dropped.

// File: rtl/reqTagPkg.sv
package reqTagPkg;
  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic wrAEn;   // first queue write this cycle
    logic wrASel;  // 0: slot 0 context, 1: slot 1 context
    logic wrBEn;   // second queue write (always slot 1)
    logic popAEn;  // tag port 0 takes an entry
    logic popBEn;  // tag port 1 takes an entry
  } trkStrobe_t;
endpackage

// File: rtl/reqTagCtrl.sv
module reqTagCtrl
  import reqTagPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PTR_W = 6,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             beatAccept,
  input  logic [1:0]       startVld,
  input  logic [1:0]       startNp,
  input  logic             tagVld0,
  input  logic             tagVld1,
  output trkStrobe_t       stb,
  output logic [PTR_W-1:0] wrAPtr,
  output logic [PTR_W-1:0] wrBPtr,
  output logic [PTR_W-1:0] rdAPtr,
  output logic [PTR_W-1:0] rdBPtr,
  output logic [CNT_W-1:0] pendCnt,
  output logic             errSticky
);
  localparam logic [CNT_W:0] DEPTH_X = (CNT_W+1)'(DEPTH);

  logic [PTR_W-1:0] headQ, tailQ;
  logic [CNT_W-1:0] cntQ;
  logic             errQ;

  logic             np0, np1;
  logic             popA, popB;
  logic [1:0]       nPop, nPush;
  logic [CNT_W-1:0] afterPop;
  logic             underErr, overErr;

  // circular pointer advance by 0..2 places
  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                            input logic [1:0] n);
    logic [PTR_W+1:0] s;
    s = {2'b00, p} + (PTR_W+2)'(n);
    if (s >= (PTR_W+2)'(DEPTH)) s = s - (PTR_W+2)'(DEPTH);
    return s[PTR_W-1:0];
  endfunction

  always_comb begin
    np0 = beatAccept & startVld[0] & startNp[0];
    np1 = beatAccept & startVld[1] & startNp[1];

    // tags take only entries that were pending at the start of the cycle
    popA = tagVld0 && (cntQ != '0);
    popB = tagVld1 && (cntQ > CNT_W'(tagVld0));
    nPop = {1'b0, popA} + {1'b0, popB};
    afterPop = cntQ - CNT_W'(nPop);

    stb = '0;
    stb.popAEn = popA;
    stb.popBEn = popB;
    stb.wrAEn  = (np0 | np1) && ({1'b0, afterPop} < DEPTH_X);
    stb.wrASel = !np0;
    stb.wrBEn  = np0 && np1 && (({1'b0, afterPop} + 1'b1) < DEPTH_X);
    nPush = {1'b0, stb.wrAEn} + {1'b0, stb.wrBEn};

    rdAPtr = headQ;
    rdBPtr = popA ? bump(headQ, 2'd1) : headQ;
    wrAPtr = tailQ;
    wrBPtr = bump(tailQ, 2'd1);

    underErr = (tagVld0 && !popA) || (tagVld1 && !popB);
    overErr  = (np0 && !stb.wrAEn) || (np1 && !(np0 ? stb.wrBEn : stb.wrAEn));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
      cntQ  <= '0;
      errQ  <= 1'b0;
    end else begin
      headQ <= bump(headQ, nPop);
      tailQ <= bump(tailQ, nPush);
      cntQ  <= afterPop + CNT_W'(nPush);
      errQ  <= errQ | underErr | overErr;
    end
  end

  assign pendCnt   = cntQ;
  assign errSticky = errQ;
endmodule

// File: rtl/reqTagData.sv
module reqTagData
  import reqTagPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PTR_W = 6,
  parameter int TAG_W = 10,
  parameter int CTX_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  trkStrobe_t       stb,
  input  logic [PTR_W-1:0] wrAPtr,
  input  logic [PTR_W-1:0] wrBPtr,
  input  logic [PTR_W-1:0] rdAPtr,
  input  logic [PTR_W-1:0] rdBPtr,
  input  logic [CTX_W-1:0] startCtx0,
  input  logic [CTX_W-1:0] startCtx1,
  input  logic [TAG_W-1:0] tag0,
  input  logic [TAG_W-1:0] tag1,
  input  logic [TAG_W-1:0] lookupTag,
  input  logic             releaseEn,
  input  logic [TAG_W-1:0] releaseTag,
  output logic             lookupHit,
  output logic [CTX_W-1:0] lookupCtx
);
  localparam int TAB_N = 1 << TAG_W;

  logic [CTX_W-1:0] fifoMem [DEPTH];
  logic [CTX_W-1:0] ctxTab  [TAB_N];
  logic [TAB_N-1:0] tabVld;

  // storage without reset: queue and context table
  always_ff @(posedge clk) begin
    if (stb.wrAEn) fifoMem[wrAPtr] <= stb.wrASel ? startCtx1 : startCtx0;
    if (stb.wrBEn) fifoMem[wrBPtr] <= startCtx1;
    if (stb.popAEn) ctxTab[tag0] <= fifoMem[rdAPtr];
    if (stb.popBEn) ctxTab[tag1] <= fifoMem[rdBPtr];  // later write wins
    lookupCtx <= ctxTab[lookupTag];
  end

  // valid bits: release first, tag writes override
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tabVld    <= '0;
      lookupHit <= 1'b0;
    end else begin
      lookupHit <= tabVld[lookupTag];
      if (releaseEn)  tabVld[releaseTag] <= 1'b0;
      if (stb.popAEn) tabVld[tag0]       <= 1'b1;
      if (stb.popBEn) tabVld[tag1]       <= 1'b1;
    end
  end
endmodule

// File: rtl/reqTagTracker.sv
module reqTagTracker
  import reqTagPkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int TAG_W      = 10,
  parameter int CTX_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             beatAccept,
  input  logic [1:0]       startVld,
  input  logic [1:0]       startNp,
  input  logic [CTX_W-1:0] startCtx0,
  input  logic [CTX_W-1:0] startCtx1,
  input  logic             tagVld0,
  input  logic [TAG_W-1:0] tag0,
  input  logic             tagVld1,
  input  logic [TAG_W-1:0] tag1,
  input  logic [TAG_W-1:0] lookupTag,
  output logic             lookupHit,
  output logic [CTX_W-1:0] lookupCtx,
  input  logic             releaseEn,
  input  logic [TAG_W-1:0] releaseTag,
  output logic             errSticky
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  trkStrobe_t       stb;
  logic [PTR_W-1:0] wrAPtr, wrBPtr, rdAPtr, rdBPtr;
  logic [CNT_W-1:0] pendCnt;

  reqTagCtrl #(.DEPTH(FIFO_DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .beatAccept(beatAccept), .startVld(startVld),
    .startNp(startNp), .tagVld0(tagVld0), .tagVld1(tagVld1), .stb(stb),
    .wrAPtr(wrAPtr), .wrBPtr(wrBPtr), .rdAPtr(rdAPtr), .rdBPtr(rdBPtr),
    .pendCnt(pendCnt), .errSticky(errSticky)
  );

  reqTagData #(.DEPTH(FIFO_DEPTH), .PTR_W(PTR_W), .TAG_W(TAG_W), .CTX_W(CTX_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAPtr(wrAPtr), .wrBPtr(wrBPtr),
    .rdAPtr(rdAPtr), .rdBPtr(rdBPtr), .startCtx0(startCtx0), .startCtx1(startCtx1),
    .tag0(tag0), .tag1(tag1), .lookupTag(lookupTag), .releaseEn(releaseEn),
    .releaseTag(releaseTag), .lookupHit(lookupHit), .lookupCtx(lookupCtx)
  );
endmodule

// File: rtl/reqTagTracker_chk.sv
module reqTagTracker_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             beatAccept,
  input logic [1:0]       startVld,
  input logic [1:0]       startNp,
  input logic             tagVld0,
  input logic             tagVld1,
  input logic [CNT_W-1:0] pendCnt,
  input logic             errSticky
);
  logic npAny;
  assign npAny = beatAccept && ((startVld & startNp) != 2'b00);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);

  // R6
  underflow_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tagVld0 && pendCnt == '0) |=> errSticky);

  // R7
  overflow_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (npAny && pendCnt == CNT_W'(DEPTH) && !tagVld0 && !tagVld1) |=> errSticky);

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= CNT_W'(DEPTH));

  // R4
  single_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!npAny && tagVld0 && !tagVld1 && pendCnt != '0) |=> pendCnt == $past(pendCnt) - 1'b1);

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!npAny && !tagVld0 && !tagVld1) |=> $stable(pendCnt));
endmodule

bind reqTagTracker reqTagTracker_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .beatAccept(beatAccept), .startVld(startVld),
  .startNp(startNp), .tagVld0(tagVld0), .tagVld1(tagVld1),
  .pendCnt(pendCnt), .errSticky(errSticky)
);

// File: tb/tb_reqTagTracker.sv
`timescale 1ns/1ps
module tb_reqTagTracker;
  localparam int DEPTH = 64;
  localparam int TAG_W = 10;
  localparam int CTX_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic beatAccept = 1'b0;
  logic [1:0] startVld = '0, startNp = '0;
  logic [CTX_W-1:0] startCtx0 = '0, startCtx1 = '0;
  logic tagVld0 = 1'b0, tagVld1 = 1'b0;
  logic [TAG_W-1:0] tag0 = '0, tag1 = '0, lookupTag = '0, releaseTag = '0;
  logic releaseEn = 1'b0;
  logic lookupHit, errSticky;
  logic [CTX_W-1:0] lookupCtx;

  always #5 clk = ~clk;

  reqTagTracker #(.FIFO_DEPTH(DEPTH), .TAG_W(TAG_W), .CTX_W(CTX_W)) dut (
    .clk(clk), .rstN(rstN), .beatAccept(beatAccept), .startVld(startVld),
    .startNp(startNp), .startCtx0(startCtx0), .startCtx1(startCtx1),
    .tagVld0(tagVld0), .tag0(tag0), .tagVld1(tagVld1), .tag1(tag1),
    .lookupTag(lookupTag), .lookupHit(lookupHit), .lookupCtx(lookupCtx),
    .releaseEn(releaseEn), .releaseTag(releaseTag), .errSticky(errSticky)
  );

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  string ph = "R1";

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp, string what);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", r, what, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [CTX_W-1:0] q[$];
  logic [CTX_W-1:0] tab[int];
  bit tv[int];
  bit mHit = 0, mErr = 0;
  logic [CTX_W-1:0] mCtx = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); tv.delete(); mHit = 0; mErr = 0;
    end else begin
      bit nHit, has0, has1;
      logic [CTX_W-1:0] nCtx, c0, c1;
      nHit = tv.exists(int'(lookupTag)) ? tv[int'(lookupTag)] : 0;
      nCtx = tab.exists(int'(lookupTag)) ? tab[int'(lookupTag)] : '0;
      has0 = 0; has1 = 0; c0 = '0; c1 = '0;
      if (tagVld0) begin
        if (q.size() > 0) begin c0 = q.pop_front(); has0 = 1; end else mErr = 1;
      end
      if (tagVld1) begin
        if (q.size() > 0) begin c1 = q.pop_front(); has1 = 1; end else mErr = 1;
      end
      if (releaseEn) tv[int'(releaseTag)] = 0;
      if (has0) begin tab[int'(tag0)] = c0; tv[int'(tag0)] = 1; end
      if (has1) begin tab[int'(tag1)] = c1; tv[int'(tag1)] = 1; end
      if (beatAccept && startVld[0] && startNp[0]) begin
        if (q.size() < DEPTH) q.push_back(startCtx0); else mErr = 1;
      end
      if (beatAccept && startVld[1] && startNp[1]) begin
        if (q.size() < DEPTH) q.push_back(startCtx1); else mErr = 1;
      end
      mHit = nHit; mCtx = nCtx;
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(ph, errSticky, mErr, "model errSticky");
      chk(ph, lookupHit, mHit, "model lookupHit");
      if (mHit) chk(ph, lookupCtx, mCtx, "model lookupCtx");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clearIn();
    beatAccept = 0; startVld = '0; startNp = '0; startCtx0 = '0; startCtx1 = '0;
    tagVld0 = 0; tagVld1 = 0; tag0 = '0; tag1 = '0; releaseEn = 0; releaseTag = '0;
  endtask

  task automatic doReset();
    clearIn();
    rstN = 0;
    repeat (3) tick();
    rstN = 1;
    tick();
  endtask

  task automatic pushBeat(bit acc, bit v0, bit n0, logic [CTX_W-1:0] c0,
                          bit v1, bit n1, logic [CTX_W-1:0] c1);
    beatAccept = acc; startVld = {v1, v0}; startNp = {n1, n0};
    startCtx0 = c0; startCtx1 = c1;
    tick();
    clearIn();
  endtask

  task automatic giveTag(bit v0, logic [TAG_W-1:0] t0, bit v1, logic [TAG_W-1:0] t1);
    tagVld0 = v0; tag0 = t0; tagVld1 = v1; tag1 = t1;
    tick();
    clearIn();
  endtask

  task automatic look(logic [TAG_W-1:0] t, bit expHit, logic [CTX_W-1:0] expCtx, string r);
    lookupTag = t;
    tick();
    chk(r, lookupHit, expHit, "lookupHit");
    if (expHit) chk(r, lookupCtx, expCtx, "lookupCtx");
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    tick();
    doReset();
    ph = "R1";
    chk("R1", errSticky, 0, "errSticky after reset");
    look(10'd7, 0, '0, "R1");

    // R2 / R9: only the accepted non-posted start queues
    ph = "R2";
    pushBeat(1, 1, 1, 16'hA001, 0, 0, 16'h0);
    pushBeat(1, 1, 0, 16'hB0B0, 0, 0, 16'h0);   // posted
    pushBeat(0, 1, 1, 16'hC0C0, 0, 0, 16'h0);   // not accepted
    repeat (3) tick();
    ph = "R9";
    lookupTag = 10'd5;
    giveTag(1, 10'd5, 0, '0);
    chk("R9", lookupHit, 0, "lookup before table write visible");
    tick();
    chk("R9", lookupHit, 1, "lookup one cycle later");
    chk("R2", lookupCtx, 16'hA001, "ctx of accepted non-posted");
    ph = "R2";
    giveTag(1, 10'd6, 0, '0);                  // nothing else pending
    chk("R2", errSticky, 1, "posted/unaccepted starts queued nothing");
    look(10'd6, 0, '0, "R2");

    // R3: two starts in one beat, slot order
    doReset();
    ph = "R3";
    pushBeat(1, 1, 1, 16'hB000, 1, 1, 16'hB001);
    tick();
    giveTag(1, 10'd10, 0, '0);
    giveTag(1, 10'd11, 0, '0);
    look(10'd10, 1, 16'hB000, "R3");
    look(10'd11, 1, 16'hB001, "R3");
    chk("R3", errSticky, 0, "no error");

    // R5: both ports, then port 1 alone
    doReset();
    ph = "R5";
    pushBeat(1, 1, 1, 16'hC000, 0, 0, '0);
    pushBeat(1, 1, 1, 16'hC001, 1, 1, 16'hC002);
    tick();
    giveTag(1, 10'd20, 1, 10'd21);
    giveTag(0, '0, 1, 10'd22);
    look(10'd20, 1, 16'hC000, "R5");
    look(10'd21, 1, 16'hC001, "R5");
    look(10'd22, 1, 16'hC002, "R4");
    chk("R5", errSticky, 0, "no error");

    // R6 / R10: underflow, then sticky
    doReset();
    ph = "R6";
    pushBeat(1, 1, 1, 16'hD000, 0, 0, '0);
    tick();
    giveTag(1, 10'd50, 1, 10'd51);             // port 1 finds nothing
    chk("R6", errSticky, 1, "port 1 underflow");
    look(10'd51, 0, '0, "R6");
    look(10'd50, 1, 16'hD000, "R6");
    ph = "R10";
    repeat (5) tick();
    chk("R10", errSticky, 1, "error stays set");

    // R7: full queue, same-cycle pop makes room, then overflow
    doReset();
    ph = "R7";
    for (int i = 0; i < DEPTH / 2; i++)
      pushBeat(1, 1, 1, 16'h1000 + 16'(2 * i), 1, 1, 16'h1000 + 16'(2 * i + 1));
    beatAccept = 1; startVld = 2'b01; startNp = 2'b01; startCtx0 = 16'hBEEF;
    tagVld0 = 1; tag0 = 10'd100;
    tick();
    clearIn();
    chk("R7", errSticky, 0, "same-cycle pop frees room");
    pushBeat(1, 1, 1, 16'hDEAD, 0, 0, '0);
    chk("R7", errSticky, 1, "push into full queue");
    for (int i = 0; i < DEPTH; i++) giveTag(1, TAG_W'(101 + i), 0, '0);
    look(10'd100, 1, 16'h1000, "R7");
    look(10'd163, 1, 16'h103F, "R7");
    look(TAG_W'(101 + DEPTH - 1), 1, 16'hBEEF, "R7");
    giveTag(1, 10'd170, 0, '0);                // dropped start left nothing
    look(10'd170, 0, '0, "R7");

    // R8: release, and write winning over release
    doReset();
    ph = "R8";
    pushBeat(1, 1, 1, 16'hE000, 1, 1, 16'hE001);
    tick();
    giveTag(1, 10'd30, 0, '0);
    look(10'd30, 1, 16'hE000, "R8");
    releaseEn = 1; releaseTag = 10'd30;
    tick();
    clearIn();
    look(10'd30, 0, '0, "R8");
    tagVld0 = 1; tag0 = 10'd31; releaseEn = 1; releaseTag = 10'd31;
    tick();
    clearIn();
    look(10'd31, 1, 16'hE001, "R8");

    // R11: same tag on both ports
    doReset();
    ph = "R11";
    pushBeat(1, 1, 1, 16'hF000, 1, 1, 16'hF001);
    tick();
    giveTag(1, 10'd40, 1, 10'd40);
    look(10'd40, 1, 16'hF001, "R11");
    chk("R11", errSticky, 0, "no error");

    tick();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule